// File: doc/BRIEF.md
# Bit-Serial Associative Search Memory

This block is a small content-addressable store holding N_WORDS entries of WIDTH bits, each with its own valid flag. A host loads entries through a plain address/data write port. It then launches a search with a key, a per-bit ignore mask and, when wanted, a close-match threshold. The store answers which entries hold the key instead of returning data by address.

The comparison is bit-serial. A position counter walks the bit positions 0 to WIDTH-1, one per clock. In each cycle the same key bit is set against that bit of every entry at once. Each entry has one single-bit coincidence cell that builds up its own result over the pass: a sticky mismatch flag, or a mismatch counter when close-match support is built in. After the last position the block registers a per-entry hit vector, a found flag and the lowest hit index, and raises a one-cycle done pulse.

The controller has three states. ST_IDLE goes to ST_SCAN when a start is accepted. ST_SCAN stays put while positions remain and goes to ST_FINISH after the last one. ST_FINISH always returns to ST_IDLE and registers the results on that transition.

Top module: `bsearch_cam`

## Requirements
- R1: After reset, busy, done, found, hit_vec and hit_idx are all zero and wr_ready is one.
- R2: The done pulse lasts exactly one cycle. It is visible in the cycle after the (WIDTH+1)-th rising edge that follows the edge accepting srch_start. busy is high from the accepting edge until that same edge and is low while done is high.
- R3: In exact mode (srch_near = 0), hit_vec bit i is 1 exactly when entry i is valid and every compared key bit equals the stored bit. Bit i of hit_vec belongs to entry address i.
- R4: A srch_mask bit of 1 removes that bit position from the comparison, so the position always counts as a coincidence. An all-ones mask hits every valid entry.
- R5: In close-match mode (srch_near = 1), an entry hits when it is valid and its number of mismatching unmasked positions is less than or equal to srch_thresh. A threshold of zero behaves as exact mode.
- R6: An entry written with wr_valid = 0 never hits, whatever its stored data. Rewriting it with wr_valid = 1 makes it searchable again.
- R7: found is 1 exactly when hit_vec is not zero. hit_idx is the lowest set index of hit_vec, or zero when there is no hit.
- R8: wr_ready is low while busy. A write presented while wr_ready is low leaves the stored data and valid flag unchanged.
- R9: srch_start is ignored while busy. The running search keeps its key, mask and timing, and no extra done pulse follows.
- R10: hit_vec, found and hit_idx change only on the edge that raises done, and hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request, taken when wr_ready is high |
| wr_addr | input | AW | Entry address to write |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Valid flag stored with the word |
| wr_ready | output | 1 | High when a write is taken (no search running) |
| srch_start | input | 1 | Start a search, taken only when idle |
| srch_key | input | WIDTH | Search key |
| srch_mask | input | WIDTH | 1 = ignore this bit position |
| srch_near | input | 1 | 1 = close-match mode |
| srch_thresh | input | CW | Largest mismatch count still accepted in close-match mode |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the results update |
| hit_vec | output | N_WORDS | Per-entry hit flags |
| found | output | 1 | At least one entry hit |
| hit_idx | output | AW | Lowest hit entry, zero when none |

## Verification
The assertions assume that rst_n is held low for at least one edge before any activity. They also assume that srch_start, wr_en and the search operands are driven to known values on every cycle, and that the host treats the results as valid only from done onward. The bench changes every input at the falling edge, keeps the operands steady while each start is sampled, and keeps write addresses within the populated range. It deliberately raises srch_start and wr_en during a running search to probe the ignore and stall rules.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } scan_state_e;
endpackage

// File: rtl/bsc_cell.sv
// One coincidence cell per stored word: accumulates the per-bit result
// of a serial pass. NEAR_EN selects a mismatch counter or a sticky flag.
module bsc_cell #(
    parameter int CW      = 4,
    parameter bit NEAR_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          key_bit,
    input  logic          care,
    input  logic          word_bit,
    output logic [CW-1:0] miss_cnt
);
    logic differ;
    assign differ = step && care && (key_bit != word_bit);

    generate
        if (NEAR_EN) begin : g_count
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) cnt_q <= '0;
                else if (differ)     cnt_q <= cnt_q + CW'(1);
            end
            assign miss_cnt = cnt_q;
        end else begin : g_flag
            logic miss_q;
            always_ff @(posedge clk) begin
                if (!rst_n || clear) miss_q <= 1'b0;
                else if (differ)     miss_q <= 1'b1;
            end
            assign miss_cnt = {{(CW-1){1'b0}}, miss_q};
        end
    endgenerate
endmodule

// File: rtl/bsc_prio.sv
// Lowest-index-first priority encoder.
module bsc_prio #(
    parameter int N  = 8,
    parameter int AW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = AW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsearch_cam.sv
module bsearch_cam
    import bsc_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int WIDTH   = 8,
    parameter bit NEAR_EN = 1'b1,
    localparam int AW = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int CW = $clog2(WIDTH + 1),
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic               srch_start,
    input  logic [WIDTH-1:0]   srch_key,
    input  logic [WIDTH-1:0]   srch_mask,
    input  logic               srch_near,
    input  logic [CW-1:0]      srch_thresh,
    output logic               busy,
    output logic               done,
    output logic [N_WORDS-1:0] hit_vec,
    output logic               found,
    output logic [AW-1:0]      hit_idx
);
    scan_state_e state_q, state_nx;

    logic [BW-1:0]    pos_q;
    logic [WIDTH-1:0] key_q, mask_q;
    logic             near_q;
    logic [CW-1:0]    thr_q;

    logic [WIDTH-1:0]   mem [N_WORDS];
    logic [N_WORDS-1:0] vld_q;

    logic               take_start, step, last_pos;
    logic [N_WORDS-1:0] word_hit;
    logic [AW-1:0]      enc_idx;
    logic               enc_any;

    logic [N_WORDS-1:0] res_vec_q;
    logic               res_found_q, done_q;
    logic [AW-1:0]      res_idx_q;

    assign last_pos = (pos_q == BW'(WIDTH - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (srch_start) state_nx = ST_SCAN;
            ST_SCAN:   if (last_pos)   state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy       = 1'b1;
        wr_ready   = 1'b0;
        take_start = 1'b0;
        step       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy       = 1'b0;
                wr_ready   = 1'b1;
                take_start = srch_start;
            end
            ST_SCAN:   step = 1'b1;
            ST_FINISH: ;
            default:   ;
        endcase
    end

    // Search operands and bit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            key_q  <= '0;
            mask_q <= '0;
            near_q <= 1'b0;
            thr_q  <= '0;
        end else if (take_start) begin
            pos_q  <= '0;
            key_q  <= srch_key;
            mask_q <= srch_mask;
            near_q <= srch_near;
            thr_q  <= srch_thresh;
        end else if (step) begin
            pos_q <= last_pos ? '0 : pos_q + BW'(1);
        end
    end

    // Entry storage; writes are only taken while idle
    always_ff @(posedge clk) begin
        if (wr_en && wr_ready && (int'(wr_addr) < N_WORDS))
            mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en && wr_ready && (int'(wr_addr) < N_WORDS))
            vld_q[wr_addr] <= wr_valid;
    end

    // One coincidence cell per word, all stepped on the same bit position
    generate
        for (genvar i = 0; i < N_WORDS; i++) begin : g_word
            logic [CW-1:0] miss;
            logic          near_ok;

            bsc_cell #(.CW(CW), .NEAR_EN(NEAR_EN)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .clear    (take_start),
                .step     (step),
                .key_bit  (key_q[pos_q]),
                .care     (!mask_q[pos_q]),
                .word_bit (mem[i][pos_q]),
                .miss_cnt (miss)
            );

            assign near_ok     = NEAR_EN && near_q && (miss <= thr_q);
            assign word_hit[i] = vld_q[i] && ((miss == '0) || near_ok);
        end
    endgenerate

    bsc_prio #(.N(N_WORDS), .AW(AW)) u_prio (
        .vec (word_hit),
        .idx (enc_idx),
        .any (enc_any)
    );

    // Result registers, loaded when leaving ST_FINISH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vec_q   <= '0;
            res_found_q <= 1'b0;
            res_idx_q   <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) begin
                res_vec_q   <= word_hit;
                res_found_q <= enc_any;
                res_idx_q   <= enc_idx;
            end
        end
    end

    assign done    = done_q;
    assign hit_vec = res_vec_q;
    assign found   = res_found_q;
    assign hit_idx = res_idx_q;
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk #(
    parameter int N_WORDS = 8,
    parameter int AW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               wr_ready,
    input logic               srch_start,
    input logic [N_WORDS-1:0] hit_vec,
    input logic               found,
    input logic [AW-1:0]      hit_idx
);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_start && !busy) |=> busy);

    // R8
    write_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

    // R7
    none_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (hit_vec == '0 && hit_idx == '0));

    // R7
    idx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> hit_vec[hit_idx]);

    // R7
    idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((hit_vec & ((N_WORDS'(1) << hit_idx) - N_WORDS'(1))) == '0));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hit_vec) && $stable(found) && $stable(hit_idx)));
endmodule

bind bsearch_cam bsc_chk #(.N_WORDS(N_WORDS), .AW(AW)) u_chk (.*);

// File: tb/sim_bsearch_cam.sv
`timescale 1ns/1ps
module sim_bsearch_cam;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int AW = 3;
    localparam int CW = 4;

    typedef struct packed {
        logic [W-1:0]  key;
        logic [W-1:0]  mask;
        logic          near;
        logic [CW-1:0] thr;
        logic [N-1:0]  exp_vec;
        logic [AW-1:0] exp_idx;
    } row_t;

    // Stored: 0:A5 1:3C 2:A5 3:FF 4:00 5:A4 6:5A(invalid) 7:0F
    localparam row_t TBL [11] = '{
        '{8'hA5, 8'h00, 1'b0, 4'd0, 8'h05, 3'd0},  // R3 exact, duplicate
        '{8'h3C, 8'h00, 1'b0, 4'd0, 8'h02, 3'd1},  // R3 exact single
        '{8'h77, 8'h00, 1'b0, 4'd0, 8'h00, 3'd0},  // R3 miss
        '{8'hA4, 8'h01, 1'b0, 4'd0, 8'h25, 3'd0},  // R4 bit0 ignored
        '{8'h00, 8'hFF, 1'b0, 4'd0, 8'hBF, 3'd0},  // R4 all ignored
        '{8'hA4, 8'h00, 1'b1, 4'd1, 8'h25, 3'd0},  // R5 distance 1
        '{8'h5A, 8'h00, 1'b0, 4'd0, 8'h00, 3'd0},  // R6 invalid entry
        '{8'hF0, 8'h00, 1'b1, 4'd4, 8'h3F, 3'd0},  // R5 distance 4
        '{8'h0F, 8'hF0, 1'b0, 4'd0, 8'h88, 3'd3},  // R4 upper ignored
        '{8'h3C, 8'h00, 1'b1, 4'd0, 8'h02, 3'd1},  // R5 zero threshold
        '{8'hFF, 8'h00, 1'b1, 4'd8, 8'hBF, 3'd0}   // R5 full threshold
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic          srch_start = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic [W-1:0]  srch_mask = '0;
    logic          srch_near = 1'b0;
    logic [CW-1:0] srch_thresh = '0;
    logic          busy, done, found;
    logic [N-1:0]  hit_vec;
    logic [AW-1:0] hit_idx;

    int n_chk = 0;
    int n_fail = 0;
    int cyc;

    always #2 clk = ~clk;

    bsearch_cam #(.N_WORDS(N), .WIDTH(W), .NEAR_EN(1'b1)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic launch(input logic [W-1:0] k, input logic [W-1:0] m,
                          input logic nr, input logic [CW-1:0] t);
        @(negedge clk);
        srch_key = k; srch_mask = m; srch_near = nr; srch_thresh = t;
        srch_start = 1'b1;
        @(negedge clk);
        srch_start = 1'b0;
        cyc = 1;
    endtask

    task automatic wait_done();
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic search(input logic [W-1:0] k, input logic [W-1:0] m,
                          input logic nr, input logic [CW-1:0] t);
        launch(k, m, nr, t);
        wait_done();
    endtask

    task automatic check_result(input string tag, input logic [N-1:0] ev, input logic [AW-1:0] ei);
        check({tag, " hit_vec"}, 32'(hit_vec), 32'(ev));
        check({"R7 ", tag, " found"}, 32'(found), 32'(ev != '0));
        check({"R7 ", tag, " hit_idx"}, 32'(hit_idx), 32'(ei));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 hit_vec", 32'(hit_vec), 0);
        check("R1 found", 32'(found), 0);
        check("R1 hit_idx", 32'(hit_idx), 0);
        check("R1 wr_ready", 32'(wr_ready), 1);
        rst_n = 1'b1;

        do_write(3'd0, 8'hA5, 1'b1);
        do_write(3'd1, 8'h3C, 1'b1);
        do_write(3'd2, 8'hA5, 1'b1);
        do_write(3'd3, 8'hFF, 1'b1);
        do_write(3'd4, 8'h00, 1'b1);
        do_write(3'd5, 8'hA4, 1'b1);
        do_write(3'd6, 8'h5A, 1'b0);
        do_write(3'd7, 8'h0F, 1'b1);

        // R2 timing of the first search
        launch(TBL[0].key, TBL[0].mask, TBL[0].near, TBL[0].thr);
        check("R2 busy after start", 32'(busy), 1);
        wait_done();
        check("R2 done latency", 32'(cyc), 32'(W + 2));
        check("R2 busy low with done", 32'(busy), 0);
        @(negedge clk);
        check("R2 done one cycle", 32'(done), 0);

        // Table walk (R3, R4, R5, R6)
        for (int r = 0; r < 11; r++) begin
            search(TBL[r].key, TBL[r].mask, TBL[r].near, TBL[r].thr);
            check($sformatf("R2 row%0d latency", r), 32'(cyc), 32'(W + 2));
            check_result($sformatf("R3/R4/R5 row%0d", r), TBL[r].exp_vec, TBL[r].exp_idx);
        end

        // R10 results hold after done
        repeat (4) @(negedge clk);
        check("R10 hit_vec held", 32'(hit_vec), 32'h0BF);
        check("R10 done low", 32'(done), 0);

        // R8 write during search is stalled
        launch(8'h3C, 8'h00, 1'b0, 4'd0);
        @(negedge clk);
        check("R8 wr_ready low", 32'(wr_ready), 0);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h00; wr_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cyc += 2;
        wait_done();
        check_result("R8 during", 8'h02, 3'd1);
        search(8'h3C, 8'h00, 1'b0, 4'd0);
        check_result("R8 entry kept", 8'h02, 3'd1);
        search(8'h00, 8'h00, 1'b0, 4'd0);
        check_result("R8 no new zero", 8'h10, 3'd4);

        // R9 start ignored while busy
        launch(8'h3C, 8'h00, 1'b0, 4'd0);
        repeat (2) @(negedge clk);
        srch_key = 8'hFF; srch_mask = 8'hFF; srch_start = 1'b1;
        @(negedge clk);
        srch_start = 1'b0;
        cyc += 3;
        wait_done();
        check("R9 latency kept", 32'(cyc), 32'(W + 2));
        check_result("R9 first key", 8'h02, 3'd1);
        begin
            int extra = 0;
            for (int k = 0; k < W + 4; k++) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            check("R9 no second search", 32'(extra), 0);
        end

        // R6 invalidate and revalidate
        do_write(3'd0, 8'hA5, 1'b0);
        search(8'hA5, 8'h00, 1'b0, 4'd0);
        check_result("R6 invalidated", 8'h04, 3'd2);
        do_write(3'd6, 8'h5A, 1'b1);
        search(8'h5A, 8'h00, 1'b0, 4'd0);
        check_result("R6 revalidated", 8'h40, 3'd6);

        finish_run();
    end
endmodule